// File: doc/BRIEF.md
# Stereo Attenuator with Soft Mute

This block scales a stereo pair of signed audio samples, one pair per sample strobe. Each channel takes an 8-bit attenuation code. Every code step is worth 0.5 dB, so the 256 codes span 0 dB down to -127.5 dB. A tracking control makes the right channel follow the left code. A soft mute comes from either a pin or a control bit. When mute is active, the output fades down to silence over a series of samples instead of being cut off at once.

Inside, each channel holds an applied level from 0 to 256. Levels 0 to 255 are attenuation codes, and level 256 means silence. The applied level moves toward its target by at most one step per sample. The same ramp handles code changes, which avoids zipper noise, and it handles mute and unmute. The gain is a fractional value looked up from the level modulo 12 (12 half-dB steps make one 6 dB octave), followed by a right shift of level/12 bits. A bypass input passes the samples through unchanged.

Top module: `stereo_attenuator`

## Requirements
- R1: After synchronous reset, `out_valid`, `out_left` and `out_right` are 0. Both applied levels are 0, so the first sample after reset passes with unity gain.
- R2: For an applied level L below 256, the output is floor(x * G(L mod 12) / 2^(16 + L/12)). Here G(r) = round(65536 * 10^(-r/40)) and L/12 is integer division.
- R3: With `track_en` = 0, the left level's target is `atten_left` and the right level's target is `atten_right`, independently.
- R4: With `track_en` = 1, both channels take `atten_left` as their target, and `atten_right` is ignored.
- R5: On each strobe, a sample is scaled with the level held before that strobe. Each level then steps by exactly one toward its target, or stays put if it is already there. Levels never change without a strobe and never exceed 256.
- R6: The effective mute is `mute_pin` OR `mute_bit`. While it is active, the target is 256. At level 256 the output is exactly 0.
- R7: When mute is released, the levels ramp back from 256 toward the code targets, again one step per strobe.
- R8: With `bypass` = 1, the strobed samples appear unchanged at the outputs, whatever the levels or mute are. The levels keep ramping during bypass.
- R9: `out_valid` is high for exactly the cycle after each strobe. Outputs hold their value between strobes.
- R10: Every code from 0 to 255 is valid. Code 255 (-127.5 dB) uses a 37-bit total shift with G(3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_valid | input | 1 | Sample strobe for one cycle |
| in_left | input | DATA_W | Left input sample, signed |
| in_right | input | DATA_W | Right input sample, signed |
| atten_left | input | 8 | Left attenuation code, 0.5 dB per count |
| atten_right | input | 8 | Right attenuation code |
| track_en | input | 1 | Right channel follows the left code |
| mute_pin | input | 1 | Mute request from a pin |
| mute_bit | input | 1 | Mute request from a control register |
| bypass | input | 1 | Pass the samples through unscaled |
| out_valid | output | 1 | Output pair valid |
| out_left | output | DATA_W | Scaled left sample |
| out_right | output | DATA_W | Scaled right sample |

## Verification
A wrong applied level shows up at the outputs on the very next strobe, as a sample scaled by the wrong power of ten. Levels are swept through all 257 values, and every strobed sample is compared against arithmetic, so a level that is off by one or has stalled is reported on the first affected sample. A mute or tracking selection that goes wrong shows as a ramp heading toward the wrong target within a single sample. A bypass leak shows as an unscaled sample immediately.

// File: rtl/stereo_att_pkg.sv
package stereo_att_pkg;
  localparam int CODE_W      = 8;
  localparam int LVL_W       = CODE_W + 1;
  localparam int LVL_SILENT  = 1 << CODE_W;
  localparam int STEPS_OCT   = 12;
  localparam int FRAC_BITS   = 16;
  localparam int GAIN_W      = FRAC_BITS + 1;
  localparam int NUM_CH      = 2;
endpackage

// File: rtl/att_gain_rom.sv
module att_gain_rom
  import stereo_att_pkg::*;
(
  input  logic [LVL_W-1:0]  idx,
  output logic [GAIN_W-1:0] gain
);
  // 10^(-r/40) scaled by 2^FRAC_BITS, r = 0..11
  always_comb begin
    case (idx)
      LVL_W'(0):  gain = GAIN_W'(65536);
      LVL_W'(1):  gain = GAIN_W'(61870);
      LVL_W'(2):  gain = GAIN_W'(58409);
      LVL_W'(3):  gain = GAIN_W'(55142);
      LVL_W'(4):  gain = GAIN_W'(52057);
      LVL_W'(5):  gain = GAIN_W'(49145);
      LVL_W'(6):  gain = GAIN_W'(46396);
      LVL_W'(7):  gain = GAIN_W'(43801);
      LVL_W'(8):  gain = GAIN_W'(41350);
      LVL_W'(9):  gain = GAIN_W'(39037);
      LVL_W'(10): gain = GAIN_W'(36854);
      LVL_W'(11): gain = GAIN_W'(34792);
      default:    gain = '0;
    endcase
  end
endmodule

// File: rtl/att_level_ramp.sv
module att_level_ramp
  import stereo_att_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             step_en,
  input  logic [LVL_W-1:0] target,
  output logic [LVL_W-1:0] level
);
  always_ff @(posedge clk) begin
    if (rst) begin
      level <= '0;
    end else if (step_en) begin
      if (level < target)      level <= level + LVL_W'(1);
      else if (level > target) level <= level - LVL_W'(1);
    end
  end
endmodule

// File: rtl/att_scale.sv
module att_scale
  import stereo_att_pkg::*;
#(
  parameter int DATA_W = 24
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     smp_valid,
  input  logic                     bypass,
  input  logic signed [DATA_W-1:0] din,
  input  logic [LVL_W-1:0]         level,
  output logic signed [DATA_W-1:0] dout
);
  localparam int PROD_W = DATA_W + GAIN_W + 1;

  logic [LVL_W-1:0]         oct;
  logic [LVL_W-1:0]         rem;
  logic [LVL_W-1:0]         shamt;
  logic [GAIN_W-1:0]        gain;
  logic signed [PROD_W-1:0] prod;

  assign oct   = level / LVL_W'(STEPS_OCT);
  assign rem   = level % LVL_W'(STEPS_OCT);
  assign shamt = LVL_W'(FRAC_BITS) + oct;

  att_gain_rom u_rom (.idx(rem), .gain(gain));

  assign prod = PROD_W'(din) * $signed({1'b0, gain});

  always_ff @(posedge clk) begin
    if (rst) begin
      dout <= '0;
    end else if (smp_valid) begin
      if (bypass)                           dout <= din;
      else if (level >= LVL_W'(LVL_SILENT)) dout <= '0;
      else                                  dout <= DATA_W'(prod >>> shamt);
    end
  end
endmodule

// File: rtl/stereo_attenuator.sv
module stereo_attenuator
  import stereo_att_pkg::*;
#(
  parameter int DATA_W = 24
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     smp_valid,
  input  logic signed [DATA_W-1:0] in_left,
  input  logic signed [DATA_W-1:0] in_right,
  input  logic [CODE_W-1:0]        atten_left,
  input  logic [CODE_W-1:0]        atten_right,
  input  logic                     track_en,
  input  logic                     mute_pin,
  input  logic                     mute_bit,
  input  logic                     bypass,
  output logic                     out_valid,
  output logic signed [DATA_W-1:0] out_left,
  output logic signed [DATA_W-1:0] out_right
);
  logic                     mute_eff;
  logic [CODE_W-1:0]        code_sel [NUM_CH];
  logic [LVL_W-1:0]         tgt      [NUM_CH];
  logic [LVL_W-1:0]         lvl      [NUM_CH];
  logic signed [DATA_W-1:0] din      [NUM_CH];
  logic signed [DATA_W-1:0] dout     [NUM_CH];
  logic [LVL_W-1:0]         lvl_left, lvl_right;

  assign mute_eff    = mute_pin | mute_bit;
  assign code_sel[0] = atten_left;
  assign code_sel[1] = track_en ? atten_left : atten_right;
  assign din[0]      = in_left;
  assign din[1]      = in_right;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    assign tgt[ch] = mute_eff ? LVL_W'(LVL_SILENT) : {1'b0, code_sel[ch]};

    att_level_ramp u_ramp (
      .clk(clk), .rst(rst), .step_en(smp_valid),
      .target(tgt[ch]), .level(lvl[ch])
    );

    att_scale #(.DATA_W(DATA_W)) u_scale (
      .clk(clk), .rst(rst), .smp_valid(smp_valid), .bypass(bypass),
      .din(din[ch]), .level(lvl[ch]), .dout(dout[ch])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= smp_valid;
  end

  assign out_left  = dout[0];
  assign out_right = dout[1];
  assign lvl_left  = lvl[0];
  assign lvl_right = lvl[1];
endmodule

// File: rtl/stereo_attenuator_chk.sv
module stereo_attenuator_chk
  import stereo_att_pkg::*;
#(
  parameter int DATA_W = 24
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     smp_valid,
  input logic                     bypass,
  input logic signed [DATA_W-1:0] in_left,
  input logic signed [DATA_W-1:0] in_right,
  input logic                     out_valid,
  input logic signed [DATA_W-1:0] out_left,
  input logic signed [DATA_W-1:0] out_right,
  input logic [LVL_W-1:0]         lvl_left,
  input logic [LVL_W-1:0]         lvl_right
);
  p_valid_after_strobe_r9: assert property (@(posedge clk) disable iff (rst)
    smp_valid |=> out_valid);

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !smp_valid |=> (!out_valid && $stable(out_left) && $stable(out_right)));

  p_level_frozen_r5: assert property (@(posedge clk) disable iff (rst)
    !smp_valid |=> ($stable(lvl_left) && $stable(lvl_right)));

  p_level_single_step_r5: assert property (@(posedge clk) disable iff (rst)
    smp_valid |=> ((lvl_left == $past(lvl_left)) ||
                   (lvl_left == $past(lvl_left) + LVL_W'(1)) ||
                   (lvl_left + LVL_W'(1) == $past(lvl_left))));

  p_level_range_r5: assert property (@(posedge clk) disable iff (rst)
    (lvl_left <= LVL_W'(LVL_SILENT)) && (lvl_right <= LVL_W'(LVL_SILENT)));

  p_bypass_pass_r8: assert property (@(posedge clk) disable iff (rst)
    (smp_valid && bypass) |=> (out_left == $past(in_left) && out_right == $past(in_right)));

  p_silent_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (smp_valid && !bypass && lvl_left == LVL_W'(LVL_SILENT)) |=> (out_left == '0));
endmodule

bind stereo_attenuator stereo_attenuator_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .smp_valid(smp_valid), .bypass(bypass),
  .in_left(in_left), .in_right(in_right), .out_valid(out_valid),
  .out_left(out_left), .out_right(out_right),
  .lvl_left(lvl_left), .lvl_right(lvl_right)
);

// File: tb/stereo_attenuator_test.sv
`timescale 1ns/1ps
module stereo_attenuator_test;
  localparam int DW = 24;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic smp_valid = 1'b0;
  logic signed [DW-1:0] in_left = '0, in_right = '0;
  logic [7:0] atten_left = '0, atten_right = '0;
  logic track_en = 1'b0, mute_pin = 1'b0, mute_bit = 1'b0, bypass = 1'b0;
  logic out_valid;
  logic signed [DW-1:0] out_left, out_right;

  int checks = 0;
  int fails = 0;
  int mdl_l = 0, mdl_r = 0;
  int seq = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  stereo_attenuator #(.DATA_W(DW)) uut (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .in_left(in_left),
    .in_right(in_right), .atten_left(atten_left), .atten_right(atten_right),
    .track_en(track_en), .mute_pin(mute_pin), .mute_bit(mute_bit),
    .bypass(bypass), .out_valid(out_valid), .out_left(out_left),
    .out_right(out_right)
  );

  function automatic longint expect_out(longint s, int lvl, bit byp);
    int q, r, g;
    longint p;
    if (byp) return s;
    if (lvl >= 256) return 0;
    q = lvl / 12;
    r = lvl % 12;
    g = $rtoi(65536.0 * (10.0 ** (-(real'(r)) / 40.0)) + 0.5);
    p = s * longint'(g);
    return p >>> (16 + q);
  endfunction

  function automatic int step_to(int cur, int tgt);
    if (cur < tgt) return cur + 1;
    if (cur > tgt) return cur - 1;
    return cur;
  endfunction

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one strobed sample, checked against the arithmetic model
  task automatic send(string req);
    longint sl, sr, el, er;
    int tl, tr;
    bit mute;
    seq++;
    sl = longint'($signed(24'(seq * 1103515245 + 12345)));
    sr = longint'($signed(24'(seq * 69069 + 7777)));
    @(negedge clk);
    in_left = DW'(sl);
    in_right = DW'(sr);
    smp_valid = 1'b1;
    mute = mute_pin | mute_bit;
    el = expect_out(sl, mdl_l, bypass);
    er = expect_out(sr, mdl_r, bypass);
    tl = mute ? 256 : int'(atten_left);
    tr = mute ? 256 : (track_en ? int'(atten_left) : int'(atten_right));
    mdl_l = step_to(mdl_l, tl);
    mdl_r = step_to(mdl_r, tr);
    @(negedge clk);
    smp_valid = 1'b0;
    check({req, " valid"}, longint'(out_valid), 1);
    check({req, " left"}, longint'(out_left), el);
    check({req, " right"}, longint'(out_right), er);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 reset valid", longint'(out_valid), 0);
    check("R1 reset left", longint'(out_left), 0);
    check("R1 reset right", longint'(out_right), 0);
    rst = 1'b0;
    send("R1 unity first sample");

    // R2 R3 R5 R10: left sweeps every level up to 255, right heads to 40
    atten_left = 8'd255;
    atten_right = 8'd40;
    for (int i = 0; i < 270; i++) send("R2_R3_R5_R10 sweep");
    check("R10 left at code 255", longint'(mdl_l), 255);

    // R5: a code change is approached one step per sample, downward
    atten_left = 8'd3;
    for (int i = 0; i < 260; i++) send("R5 ramp down");

    // R9: outputs hold and valid stays low without a strobe
    begin
      logic signed [DW-1:0] hl, hr;
      hl = out_left;
      hr = out_right;
      repeat (5) @(negedge clk);
      check("R9 hold valid", longint'(out_valid), 0);
      check("R9 hold left", longint'(out_left), longint'(hl));
      check("R9 hold right", longint'(out_right), longint'(hr));
    end

    // R4: right tracks left; atten_right ignored
    track_en = 1'b1;
    atten_left = 8'd20;
    atten_right = 8'd200;
    for (int i = 0; i < 60; i++) send("R4 tracking");
    track_en = 1'b0;

    // R6: mute from the pin ramps to silence
    mute_pin = 1'b1;
    for (int i = 0; i < 250; i++) send("R6 mute pin ramp");
    check("R6 reached silence", longint'(mdl_l), 256);
    // R8: bypass while muted passes data unchanged
    bypass = 1'b1;
    for (int i = 0; i < 8; i++) send("R8 bypass");
    bypass = 1'b0;
    // R6: register bit alone keeps mute active
    mute_pin = 1'b0;
    mute_bit = 1'b1;
    for (int i = 0; i < 10; i++) send("R6 mute bit silent");
    // R7: release ramps back
    mute_bit = 1'b0;
    for (int i = 0; i < 260; i++) send("R7 unmute ramp");
    check("R7 back at code", longint'(mdl_l), 20);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule